// File: doc/BRIEF.md
# Input Operand Precision Scheduler

This block sits in front of a multi-precision multiplier. It takes in a stream of operand pairs and sorts each pair into one of three precision classes (8, 16 or 32 bits). A pair's class is the larger of the two effective widths of its operands. Accepted pairs collect in a small buffer. When the buffer fills, or when a flush is requested, the block drains the buffer one class at a time, smallest class first, so that the supply and clock settings for the multiplier change as rarely as possible.

Each issued pair carries the following extra information:
- its class tag;
- a one-hot lane select that steers it to the 8-, 16- or 32-bit datapath;
- a clock-select code and a supply-level code, both taken from a table indexed by class;
- markers for the first and the last pair of each group.

Intake stops while the buffer is draining. It resumes in the cycle after the last pair is handed over.

Top module: `opsched_top`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and the buffer is empty.
- R2: An operand's class is 2 (32-bit) if any of bits 31..16 is set. Otherwise it is 1 (16-bit) if any of bits 15..8 is set. Otherwise it is 0 (8-bit), and this includes the value zero.
- R3: A pair's class, reported on out_prec, is the larger of its two operand classes.
- R4: in_ready is 1 while the buffer is filling and 0 for the whole drain, so no pair is accepted while out_valid is 1.
- R5: Accepting the 16th pair starts a drain with no flush; out_valid is 1 in the next cycle.
- R6: flush asserted while filling starts a drain when at least one pair is stored or is accepted in the same cycle. A flush with an empty buffer has no effect: out_valid stays 0 and in_ready stays 1.
- R7: A drain issues every stored pair exactly once. All class-0 pairs come first, then class-1, then class-2, and pairs keep their arrival order within a class.
- R8: out_lane is one-hot while out_valid is 1: bit 0 for class 0, bit 1 for class 1, bit 2 for class 2. It is all zero otherwise.
- R9: The operating-point table gives out_clk_sel/out_vdd_sel as 01/00 for class 0, 10/01 for class 1 and 11/10 for class 2.
- R10: out_first is 1 on the first issued pair of each class group. out_last is 1 on the final issued pair of each class group.
- R11: While out_valid is 1 and out_ready is 0, the issued pair and all of its tags hold steady.
- R12: In the cycle after the final pair of a drain is taken, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Scheduler can accept a pair |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| flush | input | 1 | Start draining the buffered pairs |
| out_valid | output | 1 | Issued pair valid |
| out_ready | input | 1 | Downstream takes the pair |
| out_a | output | 32 | Issued first operand |
| out_b | output | 32 | Issued second operand |
| out_prec | output | 2 | Class of the issued pair |
| out_lane | output | 3 | One-hot datapath lane select |
| out_clk_sel | output | 2 | Clock-select code for the class |
| out_vdd_sel | output | 2 | Supply-level code for the class |
| out_first | output | 1 | First pair of a class group |
| out_last | output | 1 | Last pair of a class group |

## Verification
The bench targets the following corner cases:
- **Class boundaries** (0xFF against 0x100, 0xFFFF against 0x10000, and zero). A classifier that is off by one bit would place these pairs on the wrong lane.
- **Mixed-class pairs.** A design that took the first operand's class instead of the maximum would issue these pairs too early in the drain.
- **Flush on an empty buffer.** A faulty design would enter a drain with nothing to issue.
- **Flush in the same cycle as a push.** A faulty design would drop the pair that arrived with the flush.
- **A full buffer.** A faulty design would never start on its own.
- **Random back-pressure.** This exposes any reordering within a class and any change of the presented pair while it is stalled.

// File: rtl/opsched_pkg.sv
package opsched_pkg;

    typedef enum logic [1:0] {
        PREC_8  = 2'd0,
        PREC_16 = 2'd1,
        PREC_32 = 2'd2
    } prec_e;

    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;

    localparam int NUM_CLASSES = 3;

    function automatic logic [1:0] clk_code(input logic [1:0] p);
        case (p)
            2'd0:    return 2'b01;
            2'd1:    return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [1:0] vdd_code(input logic [1:0] p);
        case (p)
            2'd0:    return 2'b00;
            2'd1:    return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

endpackage

// File: rtl/opsched_width_class.sv
module opsched_width_class
    import opsched_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SMALL_W = 8,
    parameter int MID_W   = 16
) (
    input  logic [DATA_W-1:0] value,
    output logic [1:0]        cls
);

    logic upper_set;
    logic middle_set;

    always_comb begin
        upper_set  = |value[DATA_W-1:MID_W];
        middle_set = |value[MID_W-1:SMALL_W];
        if (upper_set) begin
            cls = PREC_32;
        end else if (middle_set) begin
            cls = PREC_16;
        end else begin
            cls = PREC_8;
        end
    end

endmodule

// File: rtl/opsched_pick.sv
module opsched_pick
    import opsched_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]      pend,
    input  logic [DEPTH-1:0][1:0] cls,
    output logic                  any,
    output logic [1:0]            act_cls,
    output logic [IDX_W-1:0]      idx,
    output logic                  group_last,
    output logic                  buf_last
);

    logic [NUM_CLASSES-1:0] has_cls;
    logic [DEPTH-1:0]       match;
    logic [DEPTH-1:0]       others;

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CLASSES; gc++) begin : g_has
            logic [DEPTH-1:0] hit;
            always_comb begin
                for (int i = 0; i < DEPTH; i++) begin
                    hit[i] = pend[i] && (cls[i] == gc[1:0]);
                end
            end
            assign has_cls[gc] = |hit;
        end
    endgenerate

    always_comb begin
        any = |pend;
        if (has_cls[0]) begin
            act_cls = PREC_8;
        end else if (has_cls[1]) begin
            act_cls = PREC_16;
        end else begin
            act_cls = PREC_32;
        end

        for (int i = 0; i < DEPTH; i++) begin
            match[i] = pend[i] && (cls[i] == act_cls);
        end

        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx = i[IDX_W-1:0];
            end
        end

        group_last = ((match & (match - 1'b1)) == '0);
        others     = pend;
        others[idx] = 1'b0;
        buf_last   = (others == '0);
    end

endmodule

// File: rtl/opsched_optable.sv
module opsched_optable
    import opsched_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] cls,
    output logic [2:0] lane,
    output logic [1:0] clk_sel,
    output logic [1:0] vdd_sel
);

    genvar gl;
    generate
        for (gl = 0; gl < NUM_CLASSES; gl++) begin : g_lane
            assign lane[gl] = valid && (cls == gl[1:0]);
        end
    endgenerate

    always_comb begin
        clk_sel = clk_code(cls);
        vdd_sel = vdd_code(cls);
    end

endmodule

// File: rtl/opsched_top.sv
module opsched_top
    import opsched_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SMALL_W = 8,
    parameter int MID_W   = 16,
    parameter int DEPTH   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic              flush,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b,
    output logic [1:0]        out_prec,
    output logic [2:0]        out_lane,
    output logic [1:0]        out_clk_sel,
    output logic [1:0]        out_vdd_sel,
    output logic              out_first,
    output logic              out_last
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DEPTH - 1);

    typedef struct packed {
        phase_e                        phase;
        logic [CNT_W-1:0]              count;
        logic [DEPTH-1:0]              pend;
        logic [DEPTH-1:0][DATA_W-1:0]  a;
        logic [DEPTH-1:0][DATA_W-1:0]  b;
        logic [DEPTH-1:0][1:0]         cls;
        logic                          issued;
        logic [1:0]                    last_cls;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] opnd [2];
    logic [1:0]        opnd_cls [2];
    logic [1:0]        pair_cls;

    assign opnd[0] = in_a;
    assign opnd[1] = in_b;

    genvar go;
    generate
        for (go = 0; go < 2; go++) begin : g_cls
            opsched_width_class #(
                .DATA_W (DATA_W),
                .SMALL_W(SMALL_W),
                .MID_W  (MID_W)
            ) u_cls (
                .value(opnd[go]),
                .cls  (opnd_cls[go])
            );
        end
    endgenerate

    assign pair_cls = (opnd_cls[0] > opnd_cls[1]) ? opnd_cls[0] : opnd_cls[1];

    logic             pk_any;
    logic [1:0]       pk_cls;
    logic [IDX_W-1:0] pk_idx;
    logic             pk_group_last;
    logic             pk_buf_last;

    opsched_pick #(.DEPTH(DEPTH)) u_pick (
        .pend      (st_q.pend),
        .cls       (st_q.cls),
        .any       (pk_any),
        .act_cls   (pk_cls),
        .idx       (pk_idx),
        .group_last(pk_group_last),
        .buf_last  (pk_buf_last)
    );

    logic in_fire;
    logic out_fire;
    logic start_drain;

    assign in_ready  = (st_q.phase == PH_FILL);
    assign out_valid = (st_q.phase == PH_DRAIN) && pk_any;
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;

    always_comb begin
        st_d        = st_q;
        start_drain = 1'b0;
        if (st_q.phase == PH_FILL) begin
            if (in_fire) begin
                st_d.a[st_q.count[IDX_W-1:0]]    = in_a;
                st_d.b[st_q.count[IDX_W-1:0]]    = in_b;
                st_d.cls[st_q.count[IDX_W-1:0]]  = pair_cls;
                st_d.pend[st_q.count[IDX_W-1:0]] = 1'b1;
                st_d.count                       = st_q.count + 1'b1;
            end
            start_drain = (in_fire && (st_q.count == LAST_SLOT)) ||
                          (flush && ((st_q.count != '0) || in_fire));
            if (start_drain) begin
                st_d.phase  = PH_DRAIN;
                st_d.issued = 1'b0;
            end
        end else begin
            if (out_fire) begin
                st_d.pend[pk_idx] = 1'b0;
                st_d.issued       = 1'b1;
                st_d.last_cls     = pk_cls;
                if (pk_buf_last) begin
                    st_d.phase = PH_FILL;
                    st_d.count = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_a     = st_q.a[pk_idx];
    assign out_b     = st_q.b[pk_idx];
    assign out_prec  = out_valid ? pk_cls : 2'd0;
    assign out_first = out_valid && (!st_q.issued || (pk_cls != st_q.last_cls));
    assign out_last  = out_valid && pk_group_last;

    opsched_optable u_optable (
        .valid  (out_valid),
        .cls    (out_prec),
        .lane   (out_lane),
        .clk_sel(out_clk_sel),
        .vdd_sel(out_vdd_sel)
    );

    p_pair_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (pair_cls >= opnd_cls[0]) && (pair_cls >= opnd_cls[1]));

    p_no_intake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_full_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && st_q.count == LAST_SLOT) |=> out_valid);

    p_flush_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && in_ready && st_q.count != '0) |=> out_valid);

    p_class_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.issued) |-> (out_prec >= st_q.last_cls));

    p_lane_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_lane) == 1));

    p_lane_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_lane == 3'b000));

    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_a) &&
                                      $stable(out_b) && $stable(out_prec));

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

endmodule

// File: tb/opsched_top_test.sv
`timescale 1ns/1ps
module opsched_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        flush = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_a;
    logic [31:0] out_b;
    logic [1:0]  out_prec;
    logic [2:0]  out_lane;
    logic [1:0]  out_clk_sel;
    logic [1:0]  out_vdd_sel;
    logic        out_first;
    logic        out_last;

    always #2.5 clk = ~clk;

    opsched_top uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
        .flush(flush),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_a(out_a), .out_b(out_b), .out_prec(out_prec), .out_lane(out_lane),
        .out_clk_sel(out_clk_sel), .out_vdd_sel(out_vdd_sel),
        .out_first(out_first), .out_last(out_last)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0] qa [16];
    logic [31:0] qb [16];
    int qn = 0;

    function automatic int cls_of(input logic [31:0] x);
        if (x[31:16] != 0) return 2;
        if (x[15:8] != 0) return 1;
        return 0;
    endfunction

    function automatic int pair_of(input logic [31:0] a, input logic [31:0] b);
        int ca = cls_of(a);
        int cb = cls_of(b);
        return (ca > cb) ? ca : cb;
    endfunction

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] a, input logic [31:0] b, input bit fl);
        @(negedge clk);
        check_eq("R4", "in_ready while filling", in_ready, 1);
        in_valid = 1'b1; in_a = a; in_b = b; flush = fl;
        @(posedge clk);
        #1;
        in_valid = 1'b0; flush = 1'b0;
        qa[qn] = a; qb[qn] = b; qn++;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1;
        flush = 1'b0;
    endtask

    task automatic drain(input int rdy_pct);
        logic [31:0] ea [16];
        logic [31:0] eb [16];
        int ec [16];
        int n = 0;
        int idx = 0;
        int guard = 0;
        bit took;
        for (int c = 0; c < 3; c++) begin
            for (int i = 0; i < qn; i++) begin
                if (pair_of(qa[i], qb[i]) == c) begin
                    ea[n] = qa[i]; eb[n] = qb[i]; ec[n] = c; n++;
                end
            end
        end
        while (idx < n && guard < 400) begin
            guard++;
            @(negedge clk);
            out_ready = (($urandom % 100) < rdy_pct);
            check_eq("R7", "out_valid during drain", out_valid, 1);
            check_eq("R4", "in_ready during drain", in_ready, 0);
            check_eq("R11", "out_a", out_a, ea[idx]);
            check_eq("R11", "out_b", out_b, eb[idx]);
            check_eq("R3", "out_prec", out_prec, ec[idx]);
            check_eq("R8", "out_lane", out_lane, 1 << ec[idx]);
            check_eq("R9", "out_clk_sel", out_clk_sel, ec[idx] + 1);
            check_eq("R9", "out_vdd_sel", out_vdd_sel, ec[idx]);
            check_eq("R10", "out_first", out_first,
                     (idx == 0 || ec[idx-1] != ec[idx]) ? 1 : 0);
            check_eq("R10", "out_last", out_last,
                     (idx == n-1 || ec[idx+1] != ec[idx]) ? 1 : 0);
            took = out_ready && out_valid;
            @(posedge clk);
            if (took) idx++;
        end
        @(negedge clk);
        out_ready = 1'b0;
        check_eq("R12", "out_valid after drain", out_valid, 0);
        check_eq("R12", "in_ready after drain", in_ready, 1);
        qn = 0;
    endtask

    function automatic logic [31:0] rand_opnd();
        case ($urandom % 4)
            0: return 32'd0;
            1: return {24'd0, 8'($urandom)};
            2: return {16'd0, 16'($urandom)};
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "out_valid after reset", out_valid, 0);
        check_eq("R1", "in_ready after reset", in_ready, 1);

        // R6: a flush on an empty buffer has no effect
        do_flush();
        @(negedge clk);
        check_eq("R6", "out_valid after empty flush", out_valid, 0);
        check_eq("R6", "in_ready after empty flush", in_ready, 1);

        // R2 boundaries, R3 max of the pair, R7 grouping
        push(32'h0000_00FF, 32'h0, 1'b0);
        push(32'h0000_0100, 32'h5, 1'b0);
        push(32'h3, 32'h0000_FFFF, 1'b0);
        push(32'h0001_0000, 32'h0, 1'b0);
        push(32'h0, 32'h0, 1'b0);
        push(32'h8000_0000, 32'hFF, 1'b0);
        do_flush();
        drain(100);

        // R6: a pair accepted together with the flush is included
        push(32'h0000_1234, 32'h7, 1'b1);
        drain(100);

        // R5: a full buffer starts its own drain
        for (int i = 0; i < 16; i++) begin
            push(32'(16 - i) << (8 * (i % 3)), 32'(i), 1'b0);
        end
        drain(50);

        // random rounds with back-pressure
        for (int r = 0; r < 40; r++) begin
            int n = 1 + ($urandom % 16);
            for (int i = 0; i < n; i++) begin
                push(rand_opnd(), rand_opnd(), 1'b0);
            end
            if (n < 16) do_flush();
            drain(30 + ($urandom % 70));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule